// File: doc/BRIEF.md
# Prescaled 8-bit Timer with Compare Match

This block is an 8-bit up-counter that advances on pulses of a timer clock enable, divided by a prescaler whose ratio is chosen by a 3-bit clock-select field. Besides the count itself it holds a compare value, an interrupt-enable register and a flag register. A compare match and a counter wrap each raise an event. Each event either pulses an interrupt line for one cycle or leaves a sticky flag that software clears.

Software reaches five registers through one address, a write strobe and a write data bus. Read data is combinational from the same address. The counter can be stopped and restarted without losing its value. A clear-on-match mode turns the counter into a period generator whose period is set by the compare value.

Register map (the bench depends on these positions): address 0 control, with clock select in bits [2:0], a low mode bit in bit 3 and a high mode bit in bit 4. Address 1 is the counter, address 2 the compare value. Address 3 holds the interrupt enables: bit 0 for compare, bit 1 for overflow. Address 4 holds the flags: bit 0 for compare, bit 1 for overflow.

Top module: `tmr8_top`

## Requirements
- R1: After reset every register reads 0, the counter does not move, and both interrupt outputs are low.
- R2: Clock select 0 holds the counter. Values 1 to 7 advance it once every 1, 8, 32, 64, 128, 256 and 1024 enable pulses, counted from the moment the prescaler phase was last restarted.
- R3: Advancing from 255 to 0 sets flag bit 1. When enable bit 1 is set, it also pulses `irq_ovf` high for the cycle after that edge.
- R4: A compare value X matches on the edge where the counter advances from X to X+1. No match occurs on the edge where the counter arrives at X.
- R5: On a match, if enable bit 0 is set, `irq_cmp` is high for the following cycle and flag bit 0 is cleared. Otherwise flag bit 0 is set and `irq_cmp` stays low.
- R6: With control bits [4:3] equal to 2'b10, a match loads 0 into the counter instead of X+1. With any other value in those bits, the counter continues to X+1.
- R7: Stopping the clock and later starting it again resumes counting from the held value.
- R8: Changing clock select from 0 to a non-zero value restarts the prescaler phase. A write to the counter also restarts it.
- R9: A counter write in the same cycle as an increment wins: the counter then holds the written value.
- R10: If the count equals the compare value when either is written, or when the clock starts, the first match occurs only after a full wrap, 257 increments later.
- R11: Flag bits are cleared by writing 1 to them. Writing 0 leaves them unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_en | input | 1 | Timer clock enable feeding the prescaler |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address for both read and write |
| wdata | input | 8 | Register write data |
| rdata | output | 8 | Register read data for `addr` |
| irq_cmp | output | 1 | One-cycle compare interrupt pulse |
| irq_ovf | output | 1 | One-cycle overflow interrupt pulse |

## Verification
The bench aims at the off-by-one of the compare rule. A design that matched on arrival at X would raise the event one edge early and, in clear-on-match mode, give a period one count short. The bench checks each prescaler tap on both sides of its first increment, so a wrong tap or a phase that is not restarted shows up as a count that is off by one at the boundary. The rearm-on-equal case runs a full wrap: a design without the skip would fire on the very next edge. Stop and restart, the write-beats-increment case, and write-1-to-clear all have their own checks, so a design that reset the count on start or added an increment to a write gives a wrong read-back.

// File: rtl/tmr8_pkg.sv
package tmr8_pkg;
   localparam logic [2:0] ADDR_CTRL = 3'd0;
   localparam logic [2:0] ADDR_CNT  = 3'd1;
   localparam logic [2:0] ADDR_CMP  = 3'd2;
   localparam logic [2:0] ADDR_IEN  = 3'd3;
   localparam logic [2:0] ADDR_FLG  = 3'd4;

   localparam int unsigned SEL_W    = 3;
   localparam int unsigned NUM_TAPS = 1 << SEL_W;
   localparam logic [1:0]  MODE_CLR = 2'b10;

   // log2 of the division ratio picked by each clock-select code
   function automatic int unsigned tap_shift(int unsigned sel);
      case (sel)
         2: return 3;
         3: return 5;
         4: return 6;
         5: return 7;
         6: return 8;
         7: return 10;
         default: return 0;
      endcase
   endfunction
endpackage

// File: rtl/tmr8_prescaler.sv
module tmr8_prescaler
   import tmr8_pkg::*;
#(
   parameter int unsigned PRE_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_en,
   input  logic             restart,
   input  logic [SEL_W-1:0] sel,
   output logic             step
);
   logic [PRE_W-1:0]    pre_q;
   logic [NUM_TAPS-1:0] tap_hit;
   logic                run;

   if (PRE_W < tap_shift(NUM_TAPS - 1)) begin : g_bad_width
      $error("tmr8_prescaler: PRE_W too small for largest tap");
   end

   assign run = (sel != '0);

   assign tap_hit[0] = 1'b0;
   for (genvar k = 1; k < NUM_TAPS; k++) begin : g_tap
      localparam logic [PRE_W-1:0] MASK = PRE_W'((1 << tap_shift(k)) - 1);
      assign tap_hit[k] = ((pre_q & MASK) == MASK);
   end

   assign step = run && tick_en && tap_hit[sel];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              pre_q <= '0;
      else if (restart)        pre_q <= '0;
      else if (run && tick_en) pre_q <= pre_q + 1'b1;
   end
endmodule

// File: rtl/tmr8_counter.sv
module tmr8_counter #(
   parameter int unsigned CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step,
   input  logic             wr_cnt,
   input  logic [CNT_W-1:0] wdata,
   input  logic [CNT_W-1:0] cmp_q,
   input  logic [CNT_W-1:0] cmp_nx,
   input  logic             rearm,
   input  logic             clr_on_match,
   output logic [CNT_W-1:0] cnt_q,
   output logic             hit,
   output logic             wrap
);
   logic             skip_q, skip_d;
   logic [CNT_W-1:0] cnt_d;
   logic             adv;

   assign adv  = step && !wr_cnt;
   assign hit  = adv && (cnt_q == cmp_q) && !skip_q;
   assign wrap = adv && (cnt_q == '1) && !(hit && clr_on_match);

   always_comb begin
      if (wr_cnt)                    cnt_d = wdata;
      else if (hit && clr_on_match)  cnt_d = '0;
      else if (adv)                  cnt_d = cnt_q + 1'b1;
      else                           cnt_d = cnt_q;

      if (wr_cnt || rearm)           skip_d = (cnt_d == cmp_nx);
      else if (adv)                  skip_d = 1'b0;
      else                           skip_d = skip_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         skip_q <= 1'b0;
      end else begin
         cnt_q  <= cnt_d;
         skip_q <= skip_d;
      end
   end
endmodule

// File: rtl/tmr8_events.sv
module tmr8_events (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       hit,
   input  logic       wrap,
   input  logic [1:0] ien,
   input  logic       w1c,
   input  logic [1:0] w1c_bits,
   output logic [1:0] flg_q,
   output logic       irq_cmp,
   output logic       irq_ovf
);
   logic [1:0] flg_d;

   always_comb begin
      flg_d = w1c ? (flg_q & ~w1c_bits) : flg_q;
      if (hit)  flg_d[0] = !ien[0];
      if (wrap) flg_d[1] = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flg_q   <= '0;
         irq_cmp <= 1'b0;
         irq_ovf <= 1'b0;
      end else begin
         flg_q   <= flg_d;
         irq_cmp <= hit && ien[0];
         irq_ovf <= wrap && ien[1];
      end
   end
endmodule

// File: rtl/tmr8_top.sv
module tmr8_top
   import tmr8_pkg::*;
#(
   parameter int unsigned CNT_W = 8,
   parameter int unsigned PRE_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_en,
   input  logic             wr_en,
   input  logic [2:0]       addr,
   input  logic [CNT_W-1:0] wdata,
   output logic [CNT_W-1:0] rdata,
   output logic             irq_cmp,
   output logic             irq_ovf
);
   localparam int unsigned CTRL_W = SEL_W + 2;

   if (CNT_W < CTRL_W) begin : g_bad_cnt
      $error("tmr8_top: CNT_W must hold the control field");
   end

   logic [CTRL_W-1:0] ctrl_q;
   logic [CNT_W-1:0]  cmp_q, cmp_nx, cnt_q;
   logic [1:0]        ien_q, flg_q;
   logic              wr_ctrl, wr_cnt, wr_cmp, wr_ien, wr_flg;
   logic              start, step, hit, wrap, clr_on_match;

   assign wr_ctrl = wr_en && (addr == ADDR_CTRL);
   assign wr_cnt  = wr_en && (addr == ADDR_CNT);
   assign wr_cmp  = wr_en && (addr == ADDR_CMP);
   assign wr_ien  = wr_en && (addr == ADDR_IEN);
   assign wr_flg  = wr_en && (addr == ADDR_FLG);

   assign start        = wr_ctrl && (ctrl_q[SEL_W-1:0] == '0) && (wdata[SEL_W-1:0] != '0);
   assign cmp_nx       = wr_cmp ? wdata : cmp_q;
   assign clr_on_match = (ctrl_q[CTRL_W-1:SEL_W] == MODE_CLR);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         cmp_q  <= '0;
         ien_q  <= '0;
      end else begin
         if (wr_ctrl) ctrl_q <= wdata[CTRL_W-1:0];
         if (wr_cmp)  cmp_q  <= wdata;
         if (wr_ien)  ien_q  <= wdata[1:0];
      end
   end

   tmr8_prescaler #(.PRE_W(PRE_W)) u_pre (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick_en (tick_en),
      .restart (start || wr_cnt),
      .sel     (ctrl_q[SEL_W-1:0]),
      .step    (step)
   );

   tmr8_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk          (clk),
      .rst_n        (rst_n),
      .step         (step),
      .wr_cnt       (wr_cnt),
      .wdata        (wdata),
      .cmp_q        (cmp_q),
      .cmp_nx       (cmp_nx),
      .rearm        (wr_cmp || start),
      .clr_on_match (clr_on_match),
      .cnt_q        (cnt_q),
      .hit          (hit),
      .wrap         (wrap)
   );

   tmr8_events u_evt (
      .clk      (clk),
      .rst_n    (rst_n),
      .hit      (hit),
      .wrap     (wrap),
      .ien      (ien_q),
      .w1c      (wr_flg),
      .w1c_bits (wdata[1:0]),
      .flg_q    (flg_q),
      .irq_cmp  (irq_cmp),
      .irq_ovf  (irq_ovf)
   );

   always_comb begin
      case (addr)
         ADDR_CTRL: rdata = CNT_W'(ctrl_q);
         ADDR_CNT:  rdata = cnt_q;
         ADDR_CMP:  rdata = cmp_q;
         ADDR_IEN:  rdata = CNT_W'(ien_q);
         ADDR_FLG:  rdata = CNT_W'(flg_q);
         default:   rdata = '0;
      endcase
   end
endmodule

// File: rtl/tmr8_chk.sv
module tmr8_chk #(
   parameter int unsigned CNT_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             wr_en,
   input logic [2:0]       addr,
   input logic [CNT_W-1:0] wdata,
   input logic [4:0]       ctrl_q,
   input logic [CNT_W-1:0] cnt_q,
   input logic [CNT_W-1:0] cmp_q,
   input logic [1:0]       flg_q,
   input logic             irq_cmp,
   input logic             irq_ovf
);
   assert_stop_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_q[2:0] == 3'd0 && !(wr_en && addr == 3'd1)) |=> (cnt_q == $past(cnt_q)));

   assert_cmp_plus_one_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_cmp && $past(ctrl_q[4:3]) != 2'b10) |-> (cnt_q == $past(cmp_q) + 1'b1));

   assert_irq_clears_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
      irq_cmp |-> !flg_q[0]);

   assert_clear_on_match_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_cmp && $past(ctrl_q[4:3]) == 2'b10) |-> (cnt_q == '0));

   assert_wrap_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
      irq_ovf |-> (cnt_q == '0 && flg_q[1]));

   assert_write_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == 3'd1) |=> (cnt_q == $past(wdata)));
endmodule

bind tmr8_top tmr8_chk #(.CNT_W(CNT_W)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .wr_en   (wr_en),
   .addr    (addr),
   .wdata   (wdata),
   .ctrl_q  (ctrl_q),
   .cnt_q   (cnt_q),
   .cmp_q   (cmp_q),
   .flg_q   (flg_q),
   .irq_cmp (irq_cmp),
   .irq_ovf (irq_ovf)
);

// File: tb/tb_tmr8_top.sv
module tb_tmr8_top;
   localparam time CLK_PERIOD = 10ns;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick_en = 1'b1;
   logic       wr_en = 1'b0;
   logic [2:0] addr = 3'd0;
   logic [7:0] wdata = 8'd0;
   logic [7:0] rdata;
   logic       irq_cmp, irq_ovf;

   int checks = 0;
   int failures = 0;

   tmr8_top dut (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en),
      .addr(addr), .wdata(wdata), .rdata(rdata),
      .irq_cmp(irq_cmp), .irq_ovf(irq_ovf)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic check(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic edges(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      addr = a; wdata = d; wr_en = 1'b1;
      @(posedge clk);
      #1 wr_en = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output int v);
      addr = a;
      #1 v = int'(rdata);
   endtask

   // stop, load, then start: the start edge is the reference edge S
   task automatic setup(input int cnt, input int cmp, input int ien, input int ctrl);
      wr(3'd0, 8'd0);
      wr(3'd1, 8'(cnt));
      wr(3'd2, 8'(cmp));
      wr(3'd3, 8'(ien));
      wr(3'd4, 8'h03);
      wr(3'd0, 8'(ctrl));
   endtask

   task automatic t_reset;
      int v;
      for (int a = 0; a < 5; a++) begin
         rd(3'(a), v);
         check("R1 reg reset", v, 0);
      end
      edges(10);
      rd(3'd1, v); check("R1 stopped after reset", v, 0);
      check("R1 irq_cmp low", int'(irq_cmp), 0);
      check("R1 irq_ovf low", int'(irq_ovf), 0);
   endtask

   task automatic t_taps;
      int v;
      int divs[8] = '{0, 1, 8, 32, 64, 128, 256, 1024};
      for (int s = 1; s < 8; s++) begin
         setup(0, 200, 0, s);
         if (divs[s] > 1) begin
            edges(divs[s] - 1);
            rd(3'd1, v); check($sformatf("R2 tap %0d before step", s), v, 0);
            edges(1);
         end else edges(1);
         rd(3'd1, v); check($sformatf("R2 tap %0d first step", s), v, 1);
      end
   endtask

   task automatic t_phase;
      int v;
      setup(0, 200, 0, 2);
      edges(3);
      wr(3'd1, 8'd0);
      edges(7);
      rd(3'd1, v); check("R8 write restarts phase, before", v, 0);
      edges(1);
      rd(3'd1, v); check("R8 write restarts phase, step", v, 1);
   endtask

   task automatic t_stop_resume;
      int v;
      setup(0, 200, 0, 1);
      edges(30);
      wr(3'd0, 8'd0);
      rd(3'd1, v); check("R7 value at stop", v, 31);
      edges(20);
      rd(3'd1, v); check("R7 held while stopped", v, 31);
      wr(3'd0, 8'd1);
      edges(5);
      rd(3'd1, v); check("R7 resumes from held value", v, 36);
   endtask

   task automatic t_write_wins;
      int v;
      setup(0, 200, 0, 1);
      edges(4);
      wr(3'd1, 8'd77);
      rd(3'd1, v); check("R9 write beats increment", v, 77);
      edges(1);
      rd(3'd1, v); check("R9 counting after write", v, 78);
   endtask

   task automatic t_overflow;
      int v;
      setup(250, 100, 2, 1);
      edges(5);
      rd(3'd1, v); check("R3 at 255", v, 255);
      check("R3 no pulse before wrap", int'(irq_ovf), 0);
      edges(1);
      rd(3'd1, v); check("R3 wrapped to 0", v, 0);
      check("R3 irq_ovf pulse", int'(irq_ovf), 1);
      rd(3'd4, v); check("R3 ovf flag set", v & 2, 2);
      edges(1);
      check("R3 pulse one cycle", int'(irq_ovf), 0);
      wr(3'd4, 8'h00);
      rd(3'd4, v); check("R11 write 0 keeps flag", v & 2, 2);
      wr(3'd4, 8'h02);
      rd(3'd4, v); check("R11 write 1 clears flag", v & 2, 0);
   endtask

   task automatic t_compare;
      int v;
      setup(10, 20, 0, 1);
      edges(10);
      rd(3'd1, v); check("R4 arrive at X", v, 20);
      rd(3'd4, v); check("R4 no match on arrival", v & 1, 0);
      edges(1);
      rd(3'd4, v); check("R5 masked match sets flag", v & 1, 1);
      check("R5 masked no irq", int'(irq_cmp), 0);
      // flag left set; enabled match must clear it
      wr(3'd0, 8'd0);
      wr(3'd1, 8'd10);
      wr(3'd3, 8'd1);
      wr(3'd0, 8'd1);
      edges(10);
      check("R4 no irq on arrival", int'(irq_cmp), 0);
      edges(1);
      rd(3'd1, v); check("R4 count X+1 at match", v, 21);
      check("R5 irq_cmp pulse", int'(irq_cmp), 1);
      rd(3'd4, v); check("R5 enabled match clears flag", v & 1, 0);
      edges(1);
      check("R5 irq one cycle", int'(irq_cmp), 0);
   endtask

   task automatic t_clear_mode;
      int v;
      setup(0, 5, 0, 8'h11);
      edges(5);
      rd(3'd1, v); check("R6 reaches X", v, 5);
      edges(1);
      rd(3'd1, v); check("R6 cleared on match", v, 0);
      rd(3'd4, v); check("R6 match flagged", v & 1, 1);
      edges(5);
      rd(3'd1, v); check("R6 second period at X", v, 5);
      edges(1);
      rd(3'd1, v); check("R6 second clear", v, 0);
      setup(0, 5, 0, 8'h19);
      edges(6);
      rd(3'd1, v); check("R6 other mode continues", v, 6);
   endtask

   task automatic t_rearm_equal;
      int v;
      setup(40, 40, 0, 1);
      edges(1);
      rd(3'd1, v); check("R10 passes X without match", v, 41);
      rd(3'd4, v); check("R10 no early flag", v & 1, 0);
      edges(255);
      rd(3'd1, v); check("R10 back at X", v, 40);
      rd(3'd4, v); check("R10 still no flag", v & 1, 0);
      edges(1);
      rd(3'd4, v); check("R10 match after full wrap", v & 1, 1);
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      edges(3);
      rst_n = 1'b1;
      edges(1);
      t_reset();
      t_taps();
      t_phase();
      t_stop_resume();
      t_write_wins();
      t_overflow();
      t_compare();
      t_clear_mode();
      t_rearm_equal();
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule